// File: doc/BRIEF.md
# Programmable Countdown Interval Timer

This block is a countdown timer driven from a simple 32-bit register bus with word-aligned byte offsets. Software first stores an interval. It then writes a nonzero value to one of two trigger offsets. One trigger runs a single countdown. The other runs a countdown that refills from the stored interval each time it expires. On expiry the timer latches a pending-interrupt flag and drives the `irq` output from it.

Two more offsets stop a countdown and clear the interrupt. Each acts only on a nonzero write, and the two actions are independent of each other. A status word reports the running state and the pending state.

The bus carries register accesses and no data stream, so it has no valid/ready pair. Every access is accepted in the cycle it is presented, and there is never back-pressure. A write takes effect at the clock edge that samples it. Read data is combinational from `bus_addr` while `bus_sel` is high and `bus_we` is low. Offsets with nothing readable at them return zero.

Top module: `cdt_timer`

## Requirements
- R1: After reset the status word (offset 0) reads 0, `irq` is 0 and the interval (offset 12) reads 0.
- R2: A write to offset 12 stores the interval, and a read of offset 12 returns the stored value. Any value is accepted, including zero.
- R3: A nonzero write to offset 16 starts a single countdown of N = interval cycles. Status bit 0 (running) reads 1 for the N cycles that follow the write edge. On the N-th edge after the write edge, status bit 1 (pending) and `irq` become 1 and bit 0 becomes 0 on that same edge.
- R4: A nonzero write to offset 20 starts a repeating countdown. Expiry first occurs N edges after the write edge and then every N edges after that. The running bit stays 1 throughout.
- R5: A nonzero write to offset 4 clears the running bit at its write edge. No expiry follows, and the pending bit is left as it was.
- R6: A nonzero write to offset 8 clears the pending bit and `irq` at its write edge. The running state is left as it was.
- R7: A write of zero to offset 4, 8, 16 or 20 changes neither the status word nor `irq`.
- R8: A stored interval of zero counts as one cycle. Expiry then comes at the first edge after the start edge, and in repeating mode at every edge.
- R9: A start write while a countdown is running restarts the count from the stored interval. The count already in progress is discarded.
- R10: `irq` always equals the pending bit. Once set, the pending bit holds until it is cleared by R6. When an expiry and a clear fall on the same edge, the pending bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe for the register bus |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request, equal to the pending flag |

## Verification
A write is sampled at a rising edge, and its effect shows in the status word read just after that edge. An interval of N therefore makes the pending bit appear N edges after the start edge, and a repeating run makes it reappear every N edges. The bench drives and reads only on falling edges. Each write task returns on the falling edge right after its sampling edge. The scenario tasks count whole cycles from that point: they check that the status still shows the timer running one cycle before the expiry is due, and that the expiry has appeared on the cycle it is due, so an expiry one cycle early or one cycle late is caught.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int OFS_STATUS   = 0;
  localparam int OFS_CANCEL   = 4;
  localparam int OFS_CLRINT   = 8;
  localparam int OFS_INTERVAL = 12;
  localparam int OFS_ONESHOT  = 16;
  localparam int OFS_PERIODIC = 20;

  localparam int ST_RUN_BIT  = 0;
  localparam int ST_PEND_BIT = 1;

  typedef struct packed {
    logic cancel;
    logic clr_int;
    logic load_ivl;
    logic start_once;
    logic start_rep;
  } ctl_t;
endpackage

// File: rtl/cdt_regif.sv
module cdt_regif
  import cdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output ctl_t              ctl
);
  logic wr;
  logic nz;

  assign wr = bus_sel && bus_we;
  assign nz = |bus_wdata;

  // trigger offsets act only on nonzero data; the interval takes any value
  always_comb begin
    ctl            = '0;
    ctl.load_ivl   = wr && (bus_addr == ADDR_W'(OFS_INTERVAL));
    ctl.cancel     = wr && nz && (bus_addr == ADDR_W'(OFS_CANCEL));
    ctl.clr_int    = wr && nz && (bus_addr == ADDR_W'(OFS_CLRINT));
    ctl.start_once = wr && nz && (bus_addr == ADDR_W'(OFS_ONESHOT));
    ctl.start_rep  = wr && nz && (bus_addr == ADDR_W'(OFS_PERIODIC));
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_t             ctl,
  input  logic [CNT_W-1:0] ivl_wdata,
  output logic [CNT_W-1:0] interval_q,
  output logic [CNT_W-1:0] count_q,
  output logic             active_q,
  output logic             repeat_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload;
  logic             start;

  assign reload = (interval_q == '0) ? ONE : interval_q;
  assign start  = ctl.start_once || ctl.start_rep;
  // a control write on the final tick takes precedence over the expiry
  assign expire = active_q && (count_q == ONE) && !start && !ctl.cancel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      interval_q <= '0;
    end else if (ctl.load_ivl) begin
      interval_q <= ivl_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      active_q <= 1'b0;
      repeat_q <= 1'b0;
    end else if (start) begin
      count_q  <= reload;
      active_q <= 1'b1;
      repeat_q <= ctl.start_rep;
    end else if (ctl.cancel) begin
      count_q  <= '0;
      active_q <= 1'b0;
    end else if (active_q) begin
      if (count_q == ONE) begin
        if (repeat_q) begin
          count_q <= reload;
        end else begin
          count_q  <= '0;
          active_q <= 1'b0;
        end
      end else begin
        count_q <= count_q - ONE;
      end
    end
  end
endmodule

// File: rtl/cdt_pending.sv
module cdt_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_int,
  output logic pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (expire) begin
      pend_q <= 1'b1;
    end else if (clr_int) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  ctl_t             ctl;
  logic [CNT_W-1:0] interval_q;
  logic [CNT_W-1:0] count_q;
  logic             active_q;
  logic             repeat_q;
  logic             expire;
  logic             pend_q;

  cdt_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regif (
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctl       (ctl)
  );

  cdt_counter #(.CNT_W(CNT_W)) i_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .ivl_wdata  (bus_wdata[CNT_W-1:0]),
    .interval_q (interval_q),
    .count_q    (count_q),
    .active_q   (active_q),
    .repeat_q   (repeat_q),
    .expire     (expire)
  );

  cdt_pending i_pending (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .clr_int (ctl.clr_int),
    .pend_q  (pend_q)
  );

  assign irq = pend_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        ADDR_W'(OFS_STATUS): begin
          bus_rdata[ST_RUN_BIT]  = active_q;
          bus_rdata[ST_PEND_BIT] = pend_q;
        end
        ADDR_W'(OFS_INTERVAL): bus_rdata[CNT_W-1:0] = interval_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             active_q,
  input logic             repeat_q,
  input logic             expire,
  input logic             cancel_p,
  input logic             clr_p,
  input logic [CNT_W-1:0] count_q
);
  a_r3_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !repeat_q |=> !active_q);

  a_r4_periodic_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    expire && repeat_q |=> active_q);

  a_r10_expire_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq);

  a_r10_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_p |=> irq);

  a_r6_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    clr_p && !expire |=> !irq);

  a_r5_cancel_stops: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_p |=> !active_q);

  a_r8_count_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> count_q != '0);
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .active_q (active_q),
  .repeat_q (repeat_q),
  .expire   (expire),
  .cancel_p (ctl.cancel),
  .clr_p    (ctl.clr_int),
  .count_q  (count_q)
);

// File: tb/test_cdt_timer.sv
`timescale 1ns/1ps
module test_cdt_timer;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cdt_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(32)) i_cdt_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns on the next falling edge
  task automatic wr(input int addr, input logic [31:0] data);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(addr);
    #1;
    data = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // status word {pending, running} and irq together
  task automatic chk_st(input string req, input logic [1:0] exp);
    logic [31:0] d;
    rd(0, d);
    check(req, d, {30'd0, exp});
    check({req, " irq"}, {31'd0, irq}, {31'd0, exp[1]});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk_st("R1", 2'b00);
    rd(12, d);
    check("R1 interval", d, 32'd0);
  endtask

  task automatic t_interval_rw();
    logic [31:0] d;
    wr(12, 32'hA5A5_0007);
    rd(12, d);
    check("R2", d, 32'hA5A5_0007);
  endtask

  task automatic t_oneshot();
    wr(12, 5);
    wr(16, 1);
    chk_st("R3 running", 2'b01);
    step(4);
    chk_st("R3 before expiry", 2'b01);
    step(1);
    chk_st("R3 expiry", 2'b10);
    step(3);
    chk_st("R10 pending holds", 2'b10);
    wr(8, 1);
    chk_st("R6 clear", 2'b00);
  endtask

  task automatic t_periodic();
    wr(12, 4);
    wr(20, 1);
    step(3);
    chk_st("R4 before first", 2'b01);
    step(1);
    chk_st("R4 first expiry", 2'b11);
    wr(8, 1);
    chk_st("R6 running kept", 2'b01);
    step(2);
    chk_st("R4 before second", 2'b01);
    step(1);
    chk_st("R4 second expiry", 2'b11);
    wr(4, 1);
    chk_st("R5 cancel", 2'b10);
    step(10);
    chk_st("R5 no later expiry", 2'b10);
    wr(8, 1);
    chk_st("R6 clear", 2'b00);
  endtask

  task automatic t_zero_writes();
    wr(12, 3);
    wr(16, 1);
    step(3);
    chk_st("R7 setup", 2'b10);
    wr(8, 0);
    chk_st("R7 zero clear", 2'b10);
    wr(16, 0);
    chk_st("R7 zero oneshot", 2'b10);
    wr(20, 0);
    chk_st("R7 zero periodic", 2'b10);
    wr(12, 8);
    wr(20, 1);
    wr(4, 0);
    chk_st("R7 zero cancel", 2'b11);
    wr(4, 1);
    wr(8, 1);
    chk_st("R7 cleanup", 2'b00);
  endtask

  task automatic t_zero_interval();
    logic [31:0] d;
    wr(12, 0);
    rd(12, d);
    check("R2 zero", d, 32'd0);
    wr(16, 1);
    chk_st("R8 running", 2'b01);
    step(1);
    chk_st("R8 one tick", 2'b10);
    wr(8, 1);
    wr(20, 1);
    chk_st("R8 periodic start", 2'b01);
    step(1);
    chk_st("R8 periodic tick", 2'b11);
    wr(8, 1);
    chk_st("R10 set wins over clear", 2'b11);
    wr(4, 1);
    chk_st("R5 cancel keeps pending", 2'b10);
    wr(8, 1);
    chk_st("R6 final clear", 2'b00);
  endtask

  task automatic t_restart();
    wr(12, 6);
    wr(16, 1);
    step(3);
    wr(16, 1);
    step(5);
    chk_st("R9 restarted", 2'b01);
    step(1);
    chk_st("R9 expiry", 2'b10);
    wr(8, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_interval_rw();
    t_oneshot();
    t_periodic();
    t_zero_writes();
    t_zero_interval();
    t_restart();
    finish_run();
  end
endmodule